// File: doc/BRIEF.md
# Agreement-Chain Variable Node

This block is one variable node of a fault-tolerant low-density parity-check decoder. It combines the extrinsic messages from its check nodes through a serial chain of state-holding agreement gates. Each gate is a synchronous model of a two-input Muller C-element, and it keeps a single state bit. The chain has `DV-1` gates for a node of degree `DV`. Because each gate changes state only when its two inputs agree, a brief upset on one input is rejected.

Operation has two phases, selected by `phase`.

- **Initialization (`phase` = 0):** every outgoing message carries the channel bit. An iteration strobe presets each gate from a rotated check message.
- **Restoration (`phase` = 1):** every outgoing message carries the decision bit, which is the state of the last gate. Each strobe runs one agreement pass down the chain.

The parameter `FEEDBACK` selects one of two variants. In the plain chain, the first gate compares check messages 0 and 1. In the feedback variant, the node's own outgoing message replaces check message 0 at the first gate.

The surrounding decoder is expected to hold `phase` low for the first iteration of a codeword only.

Top module: `cel_varnode`

## Requirements
- R1: While `rst_n` is low, every gate state clears to 0, so `decided` reads 0.
- R2: A strobe with `phase`=0 loads gate k with `chk_msg[(k+DV-1) mod DV]`. For DV=4 this means gate 0 takes bit 3, gate 1 takes bit 0 and gate 2 takes bit 1, and `decided` becomes `chk_msg[1]`.
- R3: While `phase`=0, every bit of `out_msg` equals `chan_bit`.
- R4: While `phase`=1, every bit of `out_msg` equals `decided`.
- R5: On a strobe with `phase`=1, a gate whose two inputs are equal takes that value. A gate whose inputs differ keeps its state.
- R6: In the plain variant, gate 0 compares `chk_msg[0]` with `chk_msg[1]`. Each gate k>0 compares the value gate k-1 takes on the same strobe with `chk_msg[k+1]`, so agreement ripples through the whole chain in one strobe.
- R7: In the feedback variant, the first input of gate 0 is the outgoing message, which is the decision held before the strobe. The rest of the chain is as in R6.
- R8: Without a strobe, no gate state changes, whatever the inputs do.
- R9: A single-strobe flip of one check message applied to a chain preset to a common value leaves `decided` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_bit | input | 1 | Received channel bit |
| chk_msg | input | DV | Incoming check-node messages, bit i is edge i |
| phase | input | 1 | 0 = initialization, 1 = restoration |
| iter_stb | input | 1 | One-cycle strobe that marks one decoding iteration |
| out_msg | output | DV | Outgoing messages to the check nodes |
| decided | output | 1 | Corrected bit, the state of the last gate |

## Verification
The hardest situation to reach is a disagreement in the middle of the chain, where a gate holds a value that differs from its neighbours. This state arises only after an initialization with mixed rotated messages followed by restoration passes in which some comparisons fail. The random stimulus reaches it by keeping `phase` mostly high, re-initializing from time to time with random messages, and dropping strobes at random. Directed cases add an all-zero preset followed by all-ones messages, which separates the ripple of the plain chain from the held decision that the feedback variant compares against.

// File: rtl/cel_varnode.sv
module cel_varnode #(
  parameter int DV       = 4,
  parameter bit FEEDBACK = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_bit,
  input  logic [DV-1:0] chk_msg,
  input  logic          phase,
  input  logic          iter_stb,
  output logic [DV-1:0] out_msg,
  output logic          decided
);
  localparam int NC   = DV - 1;
  localparam int LAST = (2 * DV - 3) % DV;

  logic [NC-1:0] st, nx, init_val;
  logic          head_in;

  assign decided = st[NC-1];
  assign out_msg = phase ? {DV{decided}} : {DV{chan_bit}};
  assign head_in = FEEDBACK ? out_msg[0] : chk_msg[0];

  always_comb begin
    logic cin;
    nx       = st;
    init_val = '0;
    for (int k = 0; k < NC; k++) begin
      cin         = (k == 0) ? head_in : nx[k-1];
      nx[k]       = (cin == chk_msg[k+1]) ? chk_msg[k+1] : st[k];
      init_val[k] = chk_msg[(k + DV - 1) % DV];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        st <= '0;
    else if (iter_stb) st <= phase ? nx : init_val;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !iter_stb |=> $stable(st)); // R8
  AST_INIT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    iter_stb && !phase |=> st[0] == $past(chk_msg[DV-1])); // R2
  AST_INIT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    iter_stb && !phase |=> decided == $past(chk_msg[LAST])); // R2
  AST_KEEP_DISAGREE: assert property (@(posedge clk) disable iff (!rst_n)
    iter_stb && phase && (head_in != chk_msg[1]) |=> st[0] == $past(st[0])); // R5
  AST_COPY_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    iter_stb && phase && (head_in == chk_msg[1]) |=> st[0] == $past(chk_msg[1])); // R5
endmodule

// File: tb/test_cel_varnode.sv
module test_cel_varnode;
  localparam int CLK_P = 10;
  localparam int DV    = 4;

  logic          clk = 1'b0;
  logic          rst_n, chan_bit, phase, iter_stb;
  logic [DV-1:0] chk_msg, out_p, out_f;
  logic          dec_p, dec_f;
  logic [2:0]    ep, ef;
  int            total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  cel_varnode #(.DV(DV), .FEEDBACK(1'b0)) i_cel_varnode (
    .clk(clk), .rst_n(rst_n), .chan_bit(chan_bit), .chk_msg(chk_msg),
    .phase(phase), .iter_stb(iter_stb), .out_msg(out_p), .decided(dec_p));

  cel_varnode #(.DV(DV), .FEEDBACK(1'b1)) i_cel_varnode_fb (
    .clk(clk), .rst_n(rst_n), .chan_bit(chan_bit), .chk_msg(chk_msg),
    .phase(phase), .iter_stb(iter_stb), .out_msg(out_f), .decided(dec_f));

  function automatic logic [2:0] model(logic [2:0] s, logic [3:0] f, logic ph, logic fb);
    logic h, c0, c1, c2;
    if (!ph) return {f[1], f[0], f[3]};
    h  = fb ? s[2] : f[0];
    c0 = (h  == f[1]) ? f[1] : s[0];
    c1 = (c0 == f[2]) ? f[2] : s[1];
    c2 = (c1 == f[3]) ? f[3] : s[2];
    return {c2, c1, c0};
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic x, logic [3:0] f, logic ph, logic stb, string req);
    chan_bit = x; chk_msg = f; phase = ph; iter_stb = stb;
    #1;
    check(ph ? "R4" : "R3", out_p, ph ? {4{ep[2]}} : {4{x}});
    check(ph ? "R4 fb" : "R3 fb", out_f, ph ? {4{ef[2]}} : {4{x}});
    if (stb) begin
      ep = model(ep, f, ph, 1'b0);
      ef = model(ef, f, ph, 1'b1);
    end
    @(posedge clk); #1;
    check(req, {3'b0, dec_p}, {3'b0, ep[2]});
    check({req, " fb"}, {3'b0, dec_f}, {3'b0, ef[2]});
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; chan_bit = 1'b0; chk_msg = '0; phase = 1'b0; iter_stb = 1'b0;
    ep = '0; ef = '0;
    @(posedge clk); @(posedge clk); #1;
    check("R1", {2'b0, dec_f, dec_p}, 4'b0);
    rst_n = 1'b1;
    // R2: rotated preset, decided takes chk_msg[1]
    step(1'b1, 4'b1010, 1'b0, 1'b1, "R2");
    check("R2 direct", {3'b0, dec_p}, 4'b0001);
    // R8: no strobe, inputs wander
    step(1'b0, 4'b0101, 1'b1, 1'b0, "R8");
    step(1'b1, 4'b0000, 1'b0, 1'b0, "R8");
    check("R8 direct", {3'b0, dec_p}, 4'b0001);
    // R6 / R7: zero preset, then all-ones messages
    step(1'b0, 4'b0000, 1'b0, 1'b1, "R2");
    step(1'b0, 4'b1111, 1'b1, 1'b1, "R6");
    check("R6 ripple", {3'b0, dec_p}, 4'b0001);
    check("R7 held head", {3'b0, dec_f}, 4'b0000);
    // R9: preset to ones, flip one message for one strobe
    step(1'b1, 4'b1111, 1'b0, 1'b1, "R2");
    step(1'b1, 4'b1110, 1'b1, 1'b1, "R9");
    step(1'b1, 4'b1011, 1'b1, 1'b1, "R9");
    check("R9 flip", {2'b0, dec_f, dec_p}, 4'b0011);
    // R5: constrained random stimulus
    for (int i = 0; i < 600; i++) begin
      logic ph;
      ph = ($urandom % 8) != 0;
      step(1'($urandom), 4'($urandom), ph, ($urandom % 4) != 0, "R5");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule